// File: doc/BRIEF.md
# DS3 Transmit Message Interrupt Controller

This block sits between a byte-wide microprocessor bus and two transmit message engines on a DS3 line. The first engine sends far-end alarm-and-control (FEAC) codes. The second sends LAPD data-link messages. Software controls each engine through one control/status register. The controller runs a FEAC code for a fixed number of repetitions and tracks whether the data-link sender is busy. When an engine finishes, the controller latches a per-engine completion status. It masks that status with an enable and drives an active-low interrupt line to the processor.

The FEAC serializer pulses `feac_msg_done` once for each complete code it sends. The controller counts these pulses while a request is running, and the request finishes on the tenth pulse. The data-link sender reports completion with a single-cycle `dl_msg_done` pulse. Each completion status clears when software reads its register, so an interrupt service routine needs no acknowledge write.

Top module: `ds3_msg_irq_ctrl`

## Requirements
- R1: After reset, both registers read 0x00, `irq_n` is 1 and `feac_active` and `dl_active` are 0.
- R2: A write to address 0x1C with bit 1 (Go) and bit 2 (Enable) both 1, made while bit 0 (Busy) is 0, sets Busy and Go. `feac_active` rises one cycle later.
- R3: A Go write made while Busy is 1 neither restarts nor extends the running request. A Go write with bit 2 written as 0 does not start a request.
- R4: While Busy is 1, the 10th `feac_msg_done` pulse clears Busy and Go and sets bit 3 (status) of 0x1C in the next cycle. Nine pulses leave Busy set. Pulses that arrive while idle are ignored.
- R5: A read of 0x1C clears bit 3. If a completion happens in the same cycle as that read, bit 3 stays 1.
- R6: Writing 1 to bit 3 (Start) of 0x1F sets Start and bit 2 (Busy), and raises `dl_active`. A `dl_msg_done` pulse while Busy clears both bits and sets bit 0 (status).
- R7: A read of 0x1F clears bit 0. If a completion happens in the same cycle as that read, bit 0 stays 1.
- R8: `irq_n` is 0 exactly when (0x1C bit 3 and bit 4) or (0x1F bit 0 and bit 1) are set. Both enables reset to 0.
- R9: Reads of any other address return 0x00. Unused bits read 0. Writes to read-only bits have no effect.
- R10: A clearing read returns the status value from before the clear, so the read that clears a status still shows it as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read; clears status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| feac_msg_done | input | 1 | One pulse for each FEAC code sent |
| dl_msg_done | input | 1 | Data-link message complete pulse |
| feac_active | output | 1 | FEAC request running; tells the serializer to send |
| dl_active | output | 1 | Data-link request running |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions assume that `feac_msg_done` and `dl_msg_done` are single-cycle pulses. They also assume that a read strobe is held for exactly one cycle, with the address stable during it. The read-clear properties look at `bus_rdata` in the cycle after a read, and they rely on that address still being presented. The bench changes its inputs only on falling edges and holds the address between its bus tasks. It raises done pulses only as single cycles. It makes a done pulse coincide with a read only in the deliberate set-wins cases.

// File: rtl/ds3_msg_irq_pkg.sv
package ds3_msg_irq_pkg;
    // FEAC control/status register field positions
    localparam int unsigned FC_BUSY_B = 0;
    localparam int unsigned FC_GO_B   = 1;
    localparam int unsigned FC_EN_B   = 2;
    localparam int unsigned FC_IST_B  = 3;
    localparam int unsigned FC_IEN_B  = 4;
    // Data-link control/status register field positions
    localparam int unsigned DC_IST_B   = 0;
    localparam int unsigned DC_IEN_B   = 1;
    localparam int unsigned DC_BUSY_B  = 2;
    localparam int unsigned DC_START_B = 3;

    typedef struct packed {
        logic busy;
        logic start;
        logic ist;
        logic ien;
    } dl_state_t;
endpackage

// File: rtl/ds3_msg_feac_seq.sv
module ds3_msg_feac_seq
    import ds3_msg_irq_pkg::*;
#(
    parameter int unsigned REPEATS = 10,
    parameter int unsigned DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic              rd_hit,
    input  logic              wd_go,
    input  logic              wd_en,
    input  logic              wd_ien,
    input  logic              msg_done,
    output logic [DATA_W-1:0] view,
    output logic              busy,
    output logic              irq_req
);
    localparam int unsigned CNT_W = $clog2(REPEATS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(REPEATS - 1);

    typedef struct packed {
        logic             busy;
        logic             go;
        logic             en;
        logic             ist;
        logic             ien;
        logic [CNT_W-1:0] cnt;
    } feac_state_t;

    feac_state_t s_d, s_q;
    logic start_ok;
    logic finish;

    always_comb begin
        s_d      = s_q;
        start_ok = wr_hit && wd_go && wd_en && !s_q.busy;
        finish   = s_q.busy && msg_done && (s_q.cnt == LAST);
        if (wr_hit) begin
            s_d.en  = wd_en;
            s_d.ien = wd_ien;
        end
        if (start_ok) begin
            s_d.busy = 1'b1;
            s_d.go   = 1'b1;
            s_d.cnt  = '0;
        end else if (s_q.busy && msg_done) begin
            if (finish) begin
                s_d.busy = 1'b0;
                s_d.go   = 1'b0;
                s_d.cnt  = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
        // a completion in the same cycle as a clearing read wins
        s_d.ist = finish || (s_q.ist && !rd_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        view            = '0;
        view[FC_BUSY_B] = s_q.busy;
        view[FC_GO_B]   = s_q.go;
        view[FC_EN_B]   = s_q.en;
        view[FC_IST_B]  = s_q.ist;
        view[FC_IEN_B]  = s_q.ien;
    end

    assign busy    = s_q.busy;
    assign irq_req = s_q.ist && s_q.ien;
endmodule

// File: rtl/ds3_msg_dl_track.sv
module ds3_msg_dl_track
    import ds3_msg_irq_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic              rd_hit,
    input  logic              wd_start,
    input  logic              wd_ien,
    input  logic              msg_done,
    output logic [DATA_W-1:0] view,
    output logic              busy,
    output logic              irq_req
);
    dl_state_t s_d, s_q;
    logic done_ok;

    always_comb begin
        s_d     = s_q;
        done_ok = s_q.busy && msg_done;
        if (wr_hit) s_d.ien = wd_ien;
        if (done_ok) begin
            s_d.busy  = 1'b0;
            s_d.start = 1'b0;
        end else if (wr_hit && wd_start && !s_q.busy) begin
            s_d.busy  = 1'b1;
            s_d.start = 1'b1;
        end
        s_d.ist = done_ok || (s_q.ist && !rd_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        view             = '0;
        view[DC_IST_B]   = s_q.ist;
        view[DC_IEN_B]   = s_q.ien;
        view[DC_BUSY_B]  = s_q.busy;
        view[DC_START_B] = s_q.start;
    end

    assign busy    = s_q.busy;
    assign irq_req = s_q.ist && s_q.ien;
endmodule

// File: rtl/ds3_msg_bus_dec.sv
module ds3_msg_bus_dec #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8,
    parameter logic [ADDR_W-1:0] FEAC_ADDR = 8'h1C,
    parameter logic [ADDR_W-1:0] DL_ADDR   = 8'h1F
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] feac_view,
    input  logic [DATA_W-1:0] dl_view,
    input  logic              feac_irq,
    input  logic              dl_irq,
    output logic              feac_wr,
    output logic              feac_rd,
    output logic              dl_wr,
    output logic              dl_rd,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_n
);
    logic feac_sel, dl_sel;

    always_comb begin
        feac_sel = (addr == FEAC_ADDR);
        dl_sel   = (addr == DL_ADDR);
        feac_wr  = wr && feac_sel;
        feac_rd  = rd && feac_sel;
        dl_wr    = wr && dl_sel;
        dl_rd    = rd && dl_sel;
        if (feac_sel)    rdata = feac_view;
        else if (dl_sel) rdata = dl_view;
        else             rdata = '0;
        irq_n = !(feac_irq || dl_irq);
    end
endmodule

// File: rtl/ds3_msg_irq_ctrl.sv
module ds3_msg_irq_ctrl
    import ds3_msg_irq_pkg::*;
#(
    parameter int unsigned REPEATS = 10,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 8,
    parameter logic [ADDR_W-1:0] FEAC_ADDR = 8'h1C,
    parameter logic [ADDR_W-1:0] DL_ADDR   = 8'h1F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              feac_msg_done,
    input  logic              dl_msg_done,
    output logic              feac_active,
    output logic              dl_active,
    output logic              irq_n
);
    logic [DATA_W-1:0] feac_view, dl_view;
    logic feac_irq, dl_irq;
    logic feac_wr, feac_rd, dl_wr, dl_rd;
    logic unused_wbits;

    // bits that no register stores (read-only or reserved positions)
    assign unused_wbits = ^{bus_wdata[DATA_W-1:5], bus_wdata[0]};

    ds3_msg_bus_dec #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .FEAC_ADDR(FEAC_ADDR), .DL_ADDR(DL_ADDR)
    ) u_dec (
        .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .feac_view(feac_view), .dl_view(dl_view),
        .feac_irq(feac_irq), .dl_irq(dl_irq),
        .feac_wr(feac_wr), .feac_rd(feac_rd),
        .dl_wr(dl_wr), .dl_rd(dl_rd),
        .rdata(bus_rdata), .irq_n(irq_n)
    );

    ds3_msg_feac_seq #(.REPEATS(REPEATS), .DATA_W(DATA_W)) u_feac (
        .clk(clk), .rst_n(rst_n),
        .wr_hit(feac_wr), .rd_hit(feac_rd),
        .wd_go(bus_wdata[FC_GO_B]), .wd_en(bus_wdata[FC_EN_B]),
        .wd_ien(bus_wdata[FC_IEN_B]),
        .msg_done(feac_msg_done),
        .view(feac_view), .busy(feac_active), .irq_req(feac_irq)
    );

    ds3_msg_dl_track #(.DATA_W(DATA_W)) u_dl (
        .clk(clk), .rst_n(rst_n),
        .wr_hit(dl_wr), .rd_hit(dl_rd),
        .wd_start(bus_wdata[DC_START_B]), .wd_ien(bus_wdata[DC_IEN_B]),
        .msg_done(dl_msg_done),
        .view(dl_view), .busy(dl_active), .irq_req(dl_irq)
    );
endmodule

// File: rtl/ds3_msg_irq_ctrl_chk.sv
module ds3_msg_irq_ctrl_chk #(
    parameter int unsigned REPEATS = 10,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 8,
    parameter logic [ADDR_W-1:0] FEAC_ADDR = 8'h1C,
    parameter logic [ADDR_W-1:0] DL_ADDR   = 8'h1F
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              feac_msg_done,
    input logic              dl_msg_done,
    input logic              feac_active,
    input logic              dl_active,
    input logic              irq_n
);
    localparam int unsigned CW = $clog2(REPEATS + 2);
    logic [CW-1:0] pulse_cnt;
    logic unused_chk;

    assign unused_chk = ^{bus_wdata[DATA_W-1:4], bus_wdata[0]};

    // done pulses seen during the current FEAC request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        pulse_cnt <= '0;
        else if (!feac_active)             pulse_cnt <= '0;
        else if (feac_msg_done)            pulse_cnt <= pulse_cnt + 1'b1;
    end

    p_start_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(feac_active) |-> $past(bus_wr && bus_addr == FEAC_ADDR && bus_wdata[1] && bus_wdata[2]));

    p_busy_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (feac_active && !feac_msg_done) |=> feac_active);

    p_tenth_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(feac_active) |-> (pulse_cnt == CW'(REPEATS)));

    p_no_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
        feac_active |-> (pulse_cnt < CW'(REPEATS)));

    p_feac_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == FEAC_ADDR && !(feac_active && feac_msg_done))
        |=> (bus_addr != FEAC_ADDR || !bus_rdata[3]));

    p_dl_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!dl_active && bus_wr && bus_addr == DL_ADDR && bus_wdata[3]) |=> dl_active);

    p_dl_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dl_active && dl_msg_done) |=> !dl_active);

    p_dl_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == DL_ADDR && !(dl_active && dl_msg_done))
        |=> (bus_addr != DL_ADDR || !bus_rdata[0]));

    p_feac_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == FEAC_ADDR && bus_rdata[3] && bus_rdata[4]) |-> !irq_n);

    p_dl_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == DL_ADDR && bus_rdata[0] && bus_rdata[1]) |-> !irq_n);

    p_dl_busy_view_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == DL_ADDR) |-> (bus_rdata[2] == dl_active));

    p_undef_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != FEAC_ADDR && bus_addr != DL_ADDR) |-> (bus_rdata == '0));

    p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:5] == '0);
endmodule

bind ds3_msg_irq_ctrl ds3_msg_irq_ctrl_chk #(
    .REPEATS(REPEATS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .FEAC_ADDR(FEAC_ADDR), .DL_ADDR(DL_ADDR)
) u_chk (.*);

// File: tb/ds3_msg_irq_ctrl_test.sv
module ds3_msg_irq_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] FA = 8'h1C;
    localparam logic [7:0] DA = 8'h1F;
    localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_FD = 3'd2, OP_DD = 3'd3, OP_IRQ = 3'd4;
    localparam int NV = 20;
    // {requirement number, op, address, data or expected value}
    localparam logic [22:0] VEC [NV] = '{
        {4'd1, OP_RD,  DA,    8'h00},   // R1
        {4'd6, OP_WR,  DA,    8'h0A},   // R6 start + enable
        {4'd6, OP_RD,  DA,    8'h0E},   // R6
        {4'd8, OP_IRQ, 8'h00, 8'h01},   // R8 no status yet
        {4'd6, OP_DD,  8'h00, 8'h00},   // R6 done
        {4'd8, OP_IRQ, 8'h00, 8'h00},   // R8 asserted
        {4'd10, OP_RD, DA,    8'h03},   // R10 pre-clear value
        {4'd7, OP_RD,  DA,    8'h02},   // R7 cleared
        {4'd8, OP_IRQ, 8'h00, 8'h01},   // R8
        {4'd6, OP_WR,  DA,    8'h08},   // R6 start, enable off
        {4'd6, OP_DD,  8'h00, 8'h00},
        {4'd8, OP_IRQ, 8'h00, 8'h01},   // R8 masked
        {4'd7, OP_RD,  DA,    8'h01},   // R7
        {4'd9, OP_WR,  DA,    8'hF5},   // R9 read-only bits
        {4'd9, OP_RD,  DA,    8'h00},   // R9
        {4'd9, OP_RD,  8'h1D, 8'h00},   // R9 undefined address
        {4'd3, OP_WR,  FA,    8'h02},   // R3 Go without enable
        {4'd3, OP_RD,  FA,    8'h00},   // R3
        {4'd9, OP_WR,  FA,    8'hE9},   // R9 read-only bits
        {4'd9, OP_RD,  FA,    8'h00}    // R9
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic feac_msg_done = 1'b0, dl_msg_done = 1'b0;
    logic feac_active, dl_active, irq_n;
    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ds3_msg_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .feac_msg_done(feac_msg_done), .dl_msg_done(dl_msg_done),
        .feac_active(feac_active), .dl_active(dl_active), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_rd(input string req, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 check(req, bus_rdata, exp);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic feac_pulse();
        @(negedge clk); feac_msg_done = 1'b1;
        @(negedge clk); feac_msg_done = 1'b0;
    endtask

    task automatic dl_pulse();
        @(negedge clk); dl_msg_done = 1'b1;
        @(negedge clk); dl_msg_done = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done_flag) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 irq_n", {7'd0, irq_n}, 8'h01);
        check("R1 active", {6'd0, feac_active, dl_active}, 8'h00);
        do_rd("R1 feac reg", FA, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [3:0] rq; logic [2:0] op; logic [7:0] a, d;
            string tag;
            {rq, op, a, d} = VEC[i];
            tag = $sformatf("R%0d vec%0d", rq, i);
            case (op)
                OP_WR:  do_wr(a, d);
                OP_RD:  do_rd(tag, a, d);
                OP_FD:  feac_pulse();
                OP_DD:  dl_pulse();
                default: check(tag, {7'd0, irq_n}, d);
            endcase
        end

        // R2 start, R3 Go while busy ignored, R4 tenth pulse
        do_wr(FA, 8'h16);
        check("R2 active", {7'd0, feac_active}, 8'h01);
        do_rd("R2 reg", FA, 8'h17);
        for (int k = 0; k < 5; k++) feac_pulse();
        do_wr(FA, 8'h16);
        do_rd("R3 busy view", FA, 8'h17);
        for (int k = 0; k < 4; k++) feac_pulse();
        check("R4 nine pulses busy", {7'd0, feac_active}, 8'h01);
        check("R4 nine pulses irq", {7'd0, irq_n}, 8'h01);
        feac_pulse();
        check("R4 tenth done", {7'd0, feac_active}, 8'h00);
        check("R8 feac irq", {7'd0, irq_n}, 8'h00);
        do_rd("R10 feac pre-clear", FA, 8'h1C);
        do_rd("R5 feac cleared", FA, 8'h14);
        check("R8 irq released", {7'd0, irq_n}, 8'h01);
        feac_pulse();
        do_rd("R4 idle pulse ignored", FA, 8'h14);

        // R5 read coinciding with completion: set wins
        do_wr(FA, 8'h16);
        for (int k = 0; k < 9; k++) feac_pulse();
        @(negedge clk);
        bus_addr = FA; bus_rd = 1'b1; feac_msg_done = 1'b1;
        #1 check("R5 coincide read", bus_rdata, 8'h17);
        @(negedge clk);
        bus_rd = 1'b0; feac_msg_done = 1'b0;
        do_rd("R5 set wins", FA, 8'h1C);

        // R7 read coinciding with data-link completion
        do_wr(DA, 8'h0A);
        @(negedge clk);
        bus_addr = DA; bus_rd = 1'b1; dl_msg_done = 1'b1;
        #1 check("R7 coincide read", bus_rdata, 8'h0E);
        @(negedge clk);
        bus_rd = 1'b0; dl_msg_done = 1'b0;
        do_rd("R7 set wins", DA, 8'h03);
        check("R6 dl idle", {7'd0, dl_active}, 8'h00);

        done_flag = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule